// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a set of general-purpose input pins, organised in banks of 32, and records selected transitions on them as sticky status bits. Each pin has its own rising-transition enable and its own falling-transition enable. Setting both enables makes the pin report a transition in either direction. A pin whose direction input marks it as an output never records a transition.

Status bits raise interrupt requests toward an interrupt controller. Pin 0 and pin 1 each drive a dedicated request line. The status bits of every other pin, in all banks, are ORed onto one shared request line. Software clears a status bit by writing 1 to it. Writing 0 leaves a bit alone, so writing back the value just read clears exactly the bits that were seen.

Software reaches the enables and the status through a simple 32-bit register port. Writes take effect at the clock edge and reads are combinational.

Top module: `gpio_edge_irq`

## Requirements
- R1: A pin with its rising enable set records a 0-to-1 transition in its status bit. A 1-to-0 transition on a pin with only the rising enable set records nothing.
- R2: A pin with its falling enable set records a 1-to-0 transition. With both enables set, a transition in either direction is recorded.
- R3: A status bit stays set until a status write with a 1 in that bit position. Writing 0 to a status bit, or 1 to a bit that is clear, changes nothing.
- R4: Output irqPin0 is high exactly when the status bit of pin 0 is set, and irqPin1 is high exactly when the status bit of pin 1 is set.
- R5: Output irqShared is high when any status bit of pins 2 and above, in any bank, is set. The status bits of pins 0 and 1 do not affect irqShared.
- R6: When both enables of a pin are cleared, no new status is recorded for that pin. A status bit that was already set stays set until it is cleared by a write.
- R7: A pin whose pinIsInput bit is 0 never has its status bit set, whatever its enables and transitions.
- R8: A status write that clears a bit in the same cycle as a new enabled transition on that pin leaves the bit set.
- R9: During and after reset, all enable and status bits read 0 and all three request outputs are low.
- R10: The register address is {bank, select}, with bank in the upper bits and select in the low 2 bits. Select 0 addresses the rising enables, 1 the falling enables, 2 the status, and 3 reads as 0 and ignores writes. Pin n sits in bank n/32 at bit n mod 32.
- R11: A pin is sampled at each clock edge and compared with its value at the previous edge. The resulting status bit and request outputs change after the edge at which the new level is first sampled, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_BANKS*32 | Pin levels, already synchronised |
| pinIsInput | input | NUM_BANKS*32 | 1 marks a pin as an input; transitions are detected only on input pins |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | BANK_IDX_W+2 | Register address {bank, select} |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| irqPin0 | output | 1 | Request line for pin 0 |
| irqPin1 | output | 1 | Request line for pin 1 |
| irqShared | output | 1 | Combined request line for pins 2 and above |

## Verification
The bench builds the block with its default of four banks, 128 pins in all. This default places pins at the very top of the last bank, such as pin 127, and lets the shared request line collect status from every bank. Because the two-bit bank field is fully used at this size, every bank address can be driven. The tests cover the low pins that have their own lines and pins deep in the upper banks. They also make a transition and a clear land on the same bit in the same cycle.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int BANK_W = 32;

  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // Strobes from address decode to the datapath
  typedef struct packed {
    logic    wrRise;
    logic    wrFall;
    logic    wrStat;
    logic    rdOk;
    regSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_IDX_W = 2
) (
  input  logic                    regWrite,
  input  logic [BANK_IDX_W+1:0]   regAddr,
  output ctrlStrobe_t             strobe,
  output logic [BANK_IDX_W-1:0]   bankIdx
);

  logic    bankOk;
  regSel_e sel;

  always_comb begin
    bankIdx = regAddr[BANK_IDX_W+1:2];
    sel     = regSel_e'(regAddr[1:0]);
    bankOk  = ({1'b0, bankIdx} < (BANK_IDX_W+1)'(NUM_BANKS));

    strobe.sel    = sel;
    strobe.rdOk   = bankOk && (sel != SEL_NONE);
    strobe.wrRise = regWrite && bankOk && (sel == SEL_RISE);
    strobe.wrFall = regWrite && bankOk && (sel == SEL_FALL);
    strobe.wrStat = regWrite && bankOk && (sel == SEL_STAT);
  end

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BANK_W-1:0] pinIn,
  input  logic [BANK_W-1:0] pinIsInput,
  input  logic              wrRise,
  input  logic              wrFall,
  input  logic              wrStat,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] riseEn,
  output logic [BANK_W-1:0] fallEn,
  output logic [BANK_W-1:0] status
);

  logic [BANK_W-1:0] pinPrev;
  logic [BANK_W-1:0] rising;
  logic [BANK_W-1:0] falling;
  logic [BANK_W-1:0] hit;
  logic [BANK_W-1:0] clrMask;
  logic [BANK_W-1:0] statusNext;

  always_comb begin
    rising     = pinIn & ~pinPrev;
    falling    = ~pinIn & pinPrev;
    hit        = ((rising & riseEn) | (falling & fallEn)) & pinIsInput;
    clrMask    = wrStat ? wdata : '0;
    // a new edge outranks a clear of the same bit
    statusNext = (status & ~clrMask) | hit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev <= '0;
      riseEn  <= '0;
      fallEn  <= '0;
      status  <= '0;
    end else begin
      pinPrev <= pinIn;
      status  <= statusNext;
      if (wrRise) riseEn <= wdata;
      if (wrFall) fallEn <= wdata;
    end
  end

endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_IDX_W = 2,
  localparam int NUM_PINS  = NUM_BANKS * BANK_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_PINS-1:0]   pinIsInput,
  input  ctrlStrobe_t           strobe,
  input  logic [BANK_IDX_W-1:0] bankIdx,
  input  logic [BANK_W-1:0]     regWdata,
  output logic [BANK_W-1:0]     regRdata,
  output logic [NUM_PINS-1:0]   statAll,
  output logic [NUM_PINS-1:0]   riseAll,
  output logic [NUM_PINS-1:0]   fallAll,
  output logic                  irqPin0,
  output logic                  irqPin1,
  output logic                  irqShared
);

  logic [BANK_W-1:0] riseArr [NUM_BANKS];
  logic [BANK_W-1:0] fallArr [NUM_BANKS];
  logic [BANK_W-1:0] statArr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic hereSel;
    assign hereSel = ({1'b0, bankIdx} == (BANK_IDX_W+1)'(b));

    gpio_edge_bank uBank (
      .clk        (clk),
      .rstN       (rstN),
      .pinIn      (pinIn[b*BANK_W +: BANK_W]),
      .pinIsInput (pinIsInput[b*BANK_W +: BANK_W]),
      .wrRise     (strobe.wrRise && hereSel),
      .wrFall     (strobe.wrFall && hereSel),
      .wrStat     (strobe.wrStat && hereSel),
      .wdata      (regWdata),
      .riseEn     (riseArr[b]),
      .fallEn     (fallArr[b]),
      .status     (statArr[b])
    );

    assign statAll[b*BANK_W +: BANK_W] = statArr[b];
    assign riseAll[b*BANK_W +: BANK_W] = riseArr[b];
    assign fallAll[b*BANK_W +: BANK_W] = fallArr[b];
  end

  always_comb begin
    regRdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.rdOk && ({1'b0, bankIdx} == (BANK_IDX_W+1)'(b))) begin
        unique case (strobe.sel)
          SEL_RISE: regRdata = riseArr[b];
          SEL_FALL: regRdata = fallArr[b];
          SEL_STAT: regRdata = statArr[b];
          default:  regRdata = '0;
        endcase
      end
    end
  end

  assign irqPin0   = statAll[0];
  assign irqPin1   = statAll[1];
  assign irqShared = |statAll[NUM_PINS-1:2];

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  localparam int NUM_PINS   = NUM_BANKS * BANK_W,
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W     = BANK_IDX_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinIsInput,
  input  logic                regWrite,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [BANK_W-1:0]   regWdata,
  output logic [BANK_W-1:0]   regRdata,
  output logic                irqPin0,
  output logic                irqPin1,
  output logic                irqShared
);

  ctrlStrobe_t           strobe;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic [NUM_PINS-1:0]   statAll;
  logic [NUM_PINS-1:0]   riseAll;
  logic [NUM_PINS-1:0]   fallAll;

  gpio_edge_ctrl #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_IDX_W (BANK_IDX_W)
  ) uCtrl (
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strobe   (strobe),
    .bankIdx  (bankIdx)
  );

  gpio_edge_datapath #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_IDX_W (BANK_IDX_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .pinIsInput (pinIsInput),
    .strobe     (strobe),
    .bankIdx    (bankIdx),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .statAll    (statAll),
    .riseAll    (riseAll),
    .fallAll    (fallAll),
    .irqPin0    (irqPin0),
    .irqPin1    (irqPin1),
    .irqShared  (irqShared)
  );

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_PINS   = 128,
  parameter int ADDR_W     = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrite,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [31:0]         regWdata,
  input logic [NUM_PINS-1:0] pinIsInput,
  input logic [NUM_PINS-1:0] statAll,
  input logic [NUM_PINS-1:0] riseAll,
  input logic [NUM_PINS-1:0] fallAll,
  input logic                irqPin0,
  input logic                irqPin1,
  input logic                irqShared
);

  // R3: a status bit only drops in the cycle after a status-select write
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statAll) & ~statAll)) |-> $past(regWrite && regAddr[1:0] == 2'd2));

  // R6: a bit can only become set on a pin that had an enable
  assert_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statAll & ~$past(statAll) & ~($past(riseAll) | $past(fallAll)))));

  // R7: output-direction pins never gain status
  assert_input_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statAll & ~$past(statAll) & ~$past(pinIsInput))));

  // R10: a rising-enable write to bank 0 lands exactly
  assert_enable_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrite && regAddr == ADDR_W'(0)) |-> (riseAll[31:0] == $past(regWdata)));

  // R9: the first cycle out of reset shows all request lines low
  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!irqPin0 && !irqPin1 && !irqShared));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NUM_BANKS (NUM_BANKS),
  .NUM_PINS  (NUM_PINS),
  .ADDR_W    (ADDR_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrite   (regWrite),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .pinIsInput (pinIsInput),
  .statAll    (statAll),
  .riseAll    (riseAll),
  .fallAll    (fallAll),
  .irqPin0    (irqPin0),
  .irqPin1    (irqPin1),
  .irqShared  (irqShared)
);

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_BANKS  = 4;
  localparam int NUM_PINS   = NUM_BANKS * 32;

  logic                clk = 1'b0;
  logic                rstN;
  logic [NUM_PINS-1:0] pinIn;
  logic [NUM_PINS-1:0] pinIsInput;
  logic                regWrite;
  logic [3:0]          regAddr;
  logic [31:0]         regWdata;
  logic [31:0]         regRdata;
  logic                irqPin0;
  logic                irqPin1;
  logic                irqShared;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_irq #(.NUM_BANKS(NUM_BANKS)) u0 (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .pinIsInput (pinIsInput),
    .regWrite   (regWrite),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .irqPin0    (irqPin0),
    .irqPin1    (irqPin1),
    .irqShared  (irqShared)
  );

  function automatic logic [3:0] adr(input int bank, input int sel);
    return {2'(bank), 2'(sel)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input int bank, input int sel, input logic [31:0] d);
    regAddr = adr(bank, sel); regWdata = d; regWrite = 1'b1;
    tick();
    regWrite = 1'b0;
  endtask

  task automatic rdReg(input int bank, input int sel, output logic [31:0] d);
    regAddr = adr(bank, sel);
    #1;
    d = regRdata;
  endtask

  task automatic setPin(input int n, input logic v);
    pinIn[n] = v;
    tick();
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int b = 0; b < NUM_BANKS; b++)
      for (int s = 0; s < 3; s++) begin
        rdReg(b, s, d);
        check("R9 reset register", d, 32'h0);
      end
    check("R9 reset irq lines", {29'h0, irqPin0, irqPin1, irqShared}, 32'h0);
  endtask

  task automatic testRising();
    logic [31:0] d;
    wrReg(1, 0, 32'h20);                // pin 37
    pinIn[37] = 1'b1;
    rdReg(1, 2, d);
    check("R11 no status before edge", d, 32'h0);
    tick();
    rdReg(1, 2, d);
    check("R1 rising recorded", d, 32'h20);
    check("R5 shared high", {31'h0, irqShared}, 32'h1);
    check("R5 pin0 line untouched", {30'h0, irqPin0, irqPin1}, 32'h0);
    wrReg(1, 2, 32'h20);
    rdReg(1, 2, d);
    check("R3 clear by write 1", d, 32'h0);
    check("R5 shared low after clear", {31'h0, irqShared}, 32'h0);
    setPin(37, 1'b0);
    rdReg(1, 2, d);
    check("R1 falling ignored with rise only", d, 32'h0);
    wrReg(1, 0, 32'h0);
  endtask

  task automatic testFalling();
    logic [31:0] d;
    wrReg(3, 1, 32'h8000_0000);         // pin 127
    setPin(127, 1'b1);
    rdReg(3, 2, d);
    check("R2 rising ignored with fall only", d, 32'h0);
    setPin(127, 1'b0);
    rdReg(3, 2, d);
    check("R2 falling recorded pin127", d, 32'h8000_0000);
    wrReg(3, 2, 32'h8000_0000);
    wrReg(3, 1, 32'h0);
    wrReg(2, 0, 32'h1);                 // pin 64 both edges
    wrReg(2, 1, 32'h1);
    setPin(64, 1'b1);
    rdReg(2, 2, d);
    check("R2 both: rising", d, 32'h1);
    wrReg(2, 2, 32'h1);
    setPin(64, 1'b0);
    rdReg(2, 2, d);
    check("R2 both: falling", d, 32'h1);
    wrReg(2, 2, 32'h1);
    wrReg(2, 0, 32'h0);
    wrReg(2, 1, 32'h0);
  endtask

  task automatic testW1C();
    logic [31:0] d;
    wrReg(0, 0, 32'h0000_0F00);
    pinIn[8] = 1'b1; pinIn[10] = 1'b1;
    tick();
    rdReg(0, 2, d);
    check("R3 two bits set", d, 32'h500);
    wrReg(0, 2, 32'h0);
    rdReg(0, 2, d);
    check("R3 write 0 no effect", d, 32'h500);
    wrReg(0, 2, 32'h100);
    rdReg(0, 2, d);
    check("R3 single bit cleared", d, 32'h400);
    wrReg(0, 2, 32'h8000_0000);
    rdReg(0, 2, d);
    check("R3 clear of clear bit", d, 32'h400);
    wrReg(0, 2, d);
    rdReg(0, 2, d);
    check("R3 write back clears", d, 32'h0);
    wrReg(0, 0, 32'h0);
    pinIn[8] = 1'b0; pinIn[10] = 1'b0;
    tick();
  endtask

  task automatic testDedicated();
    wrReg(0, 0, 32'h3);
    setPin(0, 1'b1);
    check("R4 pin0 line", {30'h0, irqPin0, irqPin1}, 32'h2);
    check("R5 pin0 not on shared", {31'h0, irqShared}, 32'h0);
    setPin(1, 1'b1);
    check("R4 both lines", {30'h0, irqPin0, irqPin1}, 32'h3);
    check("R5 pin1 not on shared", {31'h0, irqShared}, 32'h0);
    wrReg(0, 2, 32'h1);
    check("R4 pin0 cleared only", {30'h0, irqPin0, irqPin1}, 32'h1);
    wrReg(0, 2, 32'h2);
    check("R4 both cleared", {30'h0, irqPin0, irqPin1}, 32'h0);
    wrReg(0, 0, 32'h0);
    pinIn[0] = 1'b0; pinIn[1] = 1'b0;
    tick();
  endtask

  task automatic testDisable();
    logic [31:0] d;
    wrReg(1, 0, 32'h4);                 // pin 34
    setPin(34, 1'b1);
    wrReg(1, 0, 32'h0);
    setPin(34, 1'b0);
    setPin(34, 1'b1);
    rdReg(1, 2, d);
    check("R6 set bit kept after disable", d, 32'h4);
    wrReg(1, 2, 32'h4);
    setPin(34, 1'b0);
    setPin(34, 1'b1);
    rdReg(1, 2, d);
    check("R6 no new status when disabled", d, 32'h0);
    setPin(34, 1'b0);
  endtask

  task automatic testDirection();
    logic [31:0] d;
    pinIsInput[70] = 1'b0;              // bank 2 bit 6
    wrReg(2, 0, 32'h40);
    wrReg(2, 1, 32'h40);
    setPin(70, 1'b1);
    setPin(70, 1'b0);
    rdReg(2, 2, d);
    check("R7 output pin ignored", d, 32'h0);
    check("R7 shared stays low", {31'h0, irqShared}, 32'h0);
    pinIsInput[70] = 1'b1;
    setPin(70, 1'b1);
    rdReg(2, 2, d);
    check("R7 input pin detected", d, 32'h40);
    wrReg(2, 0, 32'h0);
    wrReg(2, 1, 32'h0);
    wrReg(2, 2, 32'h40);
    setPin(70, 1'b0);
  endtask

  task automatic testCollision();
    logic [31:0] d;
    wrReg(3, 0, 32'h1);                 // pin 96
    setPin(96, 1'b1);
    setPin(96, 1'b0);
    rdReg(3, 2, d);
    check("R8 precondition set", d, 32'h1);
    regAddr = adr(3, 2); regWdata = 32'h1; regWrite = 1'b1;
    pinIn[96] = 1'b1;
    tick();
    regWrite = 1'b0;
    rdReg(3, 2, d);
    check("R8 edge beats clear", d, 32'h1);
    wrReg(3, 2, 32'h1);
    rdReg(3, 2, d);
    check("R8 later clear works", d, 32'h0);
    wrReg(3, 0, 32'h0);
    setPin(96, 1'b0);
  endtask

  task automatic testReservedSel();
    logic [31:0] d;
    wrReg(0, 0, 32'h1234_5678);
    wrReg(0, 3, 32'hFFFF_FFFF);
    rdReg(0, 3, d);
    check("R10 select 3 reads 0", d, 32'h0);
    rdReg(0, 0, d);
    check("R10 rise kept", d, 32'h1234_5678);
    rdReg(0, 1, d);
    check("R10 fall untouched", d, 32'h0);
    rdReg(0, 2, d);
    check("R10 status untouched", d, 32'h0);
    wrReg(0, 0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; pinIn = '0; pinIsInput = '1;
    regWrite = 1'b0; regAddr = '0; regWdata = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testRising();
    testFalling();
    testW1C();
    testDedicated();
    testDisable();
    testDirection();
    testCollision();
    testReservedSel();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule